// File: doc/BRIEF.md
# Nine-bit three-wire command serializer

This block writes registers of a display controller over a slow three-wire serial link made of an active-low select, a clock and one data line. Each word on the link is nine bits long. The top bit marks the word as a command, which carries a register address, or as a parameter, which carries a data byte. A frame holds one command word and then zero, one or two parameter words. All words of a frame travel inside a single select window.

The host offers a frame on a valid/ready request port. The request carries a frame kind, an address byte, a 16-bit data field and the half-period length in system clocks. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A `req_valid` raised at any other time is dropped rather than held, so the host must keep `req_valid` high until it sees the acceptance.

The data line is also read back on `lcd_sdi`. When the check is enabled, each driven bit is compared with the returned level just before the rising clock edge. A mismatch ends the frame at once and raises `err`. The block pulses `done` at the end of every frame, whether the frame completed or was aborted.

Top module: `tw_cmd_serializer`

## Requirements
- R1: Every word is 9 bits and is sent most significant bit first. Bit 8 is 0 in the command word and 1 in each parameter word. Bits 7..0 hold the address byte or the data byte.
- R2: `req_kind` selects the frame. Value 0 sends the command word only. Value 1 sends the command word and then `req_data[7:0]`. Value 2 sends the command word, then `req_data[15:8]`, then `req_data[7:0]`. Value 3 behaves like value 0.
- R3: `lcd_cs_n` falls together with the start of the first bit and stays low across every word of the frame. It rises only in the cycle where `done` is high.
- R4: For each bit, `lcd_sclk` is low with the bit already on `lcd_sdo` for H system clocks, then high for H clocks while `lcd_sdo` holds. H is `half_cnt` sampled at acceptance, and a value of 0 is treated as 1.
- R5: Out of reset and whenever `busy` is low, the outputs are at their idle levels: `lcd_cs_n`=1, `lcd_sclk`=1, `lcd_sdo`=0 and `lcd_sdo_oe`=0. In the same conditions `req_ready`=1, `done`=0 and `err`=0 after reset.
- R6: With CHECK_EN=1, `lcd_sdi` is compared with the driven bit in the last cycle of that bit's low phase. On a mismatch that bit gets no rising clock edge, the frame ends and `err` rises.
- R7: `done` is high for exactly one cycle at the end of every frame, including aborted frames. In that cycle `lcd_cs_n` and `lcd_sclk` are already high.
- R8: With CHECK_EN=0, `lcd_sdi` is ignored, every frame runs to its last bit and `err` stays 0.
- R9: `req_ready` is low while `busy` is high. A `req_valid` raised then is ignored and starts no frame later.
- R10: `err` keeps its value until the next accepted request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Frame request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_kind | input | 2 | Frame kind (see R2) |
| req_addr | input | 8 | Register address byte |
| req_data | input | 16 | Parameter data, high byte sent first |
| half_cnt | input | 16 | Half-period length in system clocks |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Read-back mismatch seen on the last frame |
| lcd_cs_n | output | 1 | Link select, active low |
| lcd_sclk | output | 1 | Link clock, idle high |
| lcd_sdo | output | 1 | Data driven to the link |
| lcd_sdo_oe | output | 1 | Data pad direction, 1 while driving |
| lcd_sdi | input | 1 | Data level read back from the link |

## Verification
The bench builds the block twice with DIV_W=12. One copy has CHECK_EN=1 and has its read-back wired to its own data output through a fault injector. The other copy has CHECK_EN=0 and its read-back tied low, so every 1 bit it sends would mismatch if the check were active. Half periods of 0, 1, 2 and 3 clocks keep a 27-bit frame to a few hundred cycles, which makes every frame kind, a forced mismatch in the middle of a parameter word, and a request raised during a frame cheap to reach.

// File: rtl/tw_ser_pkg.sv
package tw_ser_pkg;
  typedef enum logic [1:0] {
    FK_CMD     = 2'd0,
    FK_CMD_B8  = 2'd1,
    FK_CMD_B16 = 2'd2,
    FK_RSVD    = 2'd3
  } frame_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_FIN  = 2'd3
  } ser_state_e;
endpackage

// File: rtl/tw_frame_pack.sv
module tw_frame_pack
  import tw_ser_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int DATA_BYTES = 2,
  localparam int WORD_W    = BYTE_W + 1,
  localparam int FRAME_W   = WORD_W * (DATA_BYTES + 1),
  localparam int CNT_W     = $clog2(FRAME_W + 1)
) (
  input  logic [1:0]                   kind,
  input  logic [BYTE_W-1:0]            addr,
  input  logic [BYTE_W*DATA_BYTES-1:0] data,
  output logic [FRAME_W-1:0]           frame,
  output logic [CNT_W-1:0]             nbits
);
  frame_kind_e kind_e;
  int          nbytes;
  logic [BYTE_W-1:0] byte_v;

  assign kind_e = frame_kind_e'(kind);

  always_comb begin
    case (kind_e)
      FK_CMD_B8:  nbytes = 1;
      FK_CMD_B16: nbytes = DATA_BYTES;
      default:    nbytes = 0;
    endcase
    frame  = '0;
    byte_v = '0;
    // command word: flag bit clear, address below it
    frame[FRAME_W-1 -: WORD_W] = {1'b0, addr};
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (i < nbytes) begin
        byte_v = BYTE_W'(data >> (BYTE_W * (nbytes - 1 - i)));
        frame[FRAME_W-1-WORD_W*(i+1) -: WORD_W] = {1'b1, byte_v};
      end
    end
    nbits = CNT_W'(WORD_W * (nbytes + 1));
  end
endmodule

// File: rtl/tw_half_timer.sv
module tw_half_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             restart,
  input  logic [DIV_W-1:0] limit_in,
  output logic             phase_last
);
  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= DIV_W'(1);
      cnt_q <= '0;
    end else begin
      if (load)
        lim_q <= (limit_in == '0) ? DIV_W'(1) : limit_in;
      if (restart)
        cnt_q <= '0;
      else if (cnt_q != lim_q - DIV_W'(1))
        cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign phase_last = (cnt_q == lim_q - DIV_W'(1));
endmodule

// File: rtl/tw_bit_engine.sv
module tw_bit_engine
  import tw_ser_pkg::*;
#(
  parameter int FRAME_W  = 27,
  parameter int CNT_W    = 5,
  parameter bit CHECK_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  input  logic               sdi,
  input  logic               phase_last,
  output ser_state_e         state_o,
  output logic               bit_o,
  output logic               err_o,
  output logic               restart_o
);
  ser_state_e         state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               err_q;
  logic               mism;

  generate
    if (CHECK_EN) begin : g_chk
      assign mism = sdi ^ sh_q[FRAME_W-1];
    end else begin : g_nochk
      assign mism = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          sh_q    <= frame_in;
          left_q  <= nbits_in;
          err_q   <= 1'b0;
          state_q <= ST_LOW;
        end
        ST_LOW: if (phase_last) begin
          if (mism) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: if (phase_last) begin
          if (left_q == CNT_W'(1)) begin
            state_q <= ST_FIN;
          end else begin
            left_q  <= left_q - CNT_W'(1);
            sh_q    <= sh_q << 1;
            state_q <= ST_LOW;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign bit_o     = sh_q[FRAME_W-1];
  assign err_o     = err_q;
  assign restart_o = accept || (((state_q == ST_LOW) || (state_q == ST_HIGH)) && phase_last);
endmodule

// File: rtl/tw_cmd_serializer.sv
module tw_cmd_serializer
  import tw_ser_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int DATA_BYTES = 2,
  parameter int DIV_W      = 16,
  parameter bit CHECK_EN   = 1'b1,
  localparam int WORD_W    = BYTE_W + 1,
  localparam int FRAME_W   = WORD_W * (DATA_BYTES + 1),
  localparam int CNT_W     = $clog2(FRAME_W + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_kind,
  input  logic [BYTE_W-1:0]            req_addr,
  input  logic [BYTE_W*DATA_BYTES-1:0] req_data,
  input  logic [DIV_W-1:0]             half_cnt,
  output logic                         busy,
  output logic                         done,
  output logic                         err,
  output logic                         lcd_cs_n,
  output logic                         lcd_sclk,
  output logic                         lcd_sdo,
  output logic                         lcd_sdo_oe,
  input  logic                         lcd_sdi
);
  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   nbits_w;
  logic               accept;
  logic               phase_last;
  logic               restart;
  logic               bit_w;
  ser_state_e         state_w;
  logic               shifting;

  assign accept = req_valid && (state_w == ST_IDLE);

  tw_frame_pack #(
    .BYTE_W     (BYTE_W),
    .DATA_BYTES (DATA_BYTES)
  ) pack_i (
    .kind  (req_kind),
    .addr  (req_addr),
    .data  (req_data),
    .frame (frame_w),
    .nbits (nbits_w)
  );

  tw_half_timer #(
    .DIV_W (DIV_W)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .restart    (restart),
    .limit_in   (half_cnt),
    .phase_last (phase_last)
  );

  tw_bit_engine #(
    .FRAME_W  (FRAME_W),
    .CNT_W    (CNT_W),
    .CHECK_EN (CHECK_EN)
  ) engine_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .frame_in   (frame_w),
    .nbits_in   (nbits_w),
    .sdi        (lcd_sdi),
    .phase_last (phase_last),
    .state_o    (state_w),
    .bit_o      (bit_w),
    .err_o      (err),
    .restart_o  (restart)
  );

  assign shifting   = (state_w == ST_LOW) || (state_w == ST_HIGH);
  assign req_ready  = (state_w == ST_IDLE);
  assign busy       = (state_w != ST_IDLE);
  assign done       = (state_w == ST_FIN);
  assign lcd_cs_n   = !shifting;
  assign lcd_sclk   = (state_w != ST_LOW);
  assign lcd_sdo    = shifting && bit_w;
  assign lcd_sdo_oe = shifting;
endmodule

// File: rtl/tw_ser_chk.sv
module tw_ser_chk #(
  parameter bit CHECK_EN = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic err,
  input logic lcd_cs_n,
  input logic lcd_sclk,
  input logic lcd_sdo,
  input logic lcd_sdo_oe
);
  // R5
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_cs_n && lcd_sclk && !lcd_sdo && !lcd_sdo_oe));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lcd_cs_n && lcd_sclk));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cs_n) |-> done);

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && lcd_sclk && $past(!lcd_cs_n && lcd_sclk)) |-> $stable(lcd_sdo));

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(req_valid && req_ready)) |=> err);

  // R6
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  generate
    if (!CHECK_EN) begin : g_nochk
      // R8
      err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !err);
    end
  endgenerate
endmodule

bind tw_cmd_serializer tw_ser_chk #(.CHECK_EN(CHECK_EN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .lcd_cs_n   (lcd_cs_n),
  .lcd_sclk   (lcd_sclk),
  .lcd_sdo    (lcd_sdo),
  .lcd_sdo_oe (lcd_sdo_oe)
);

// File: tb/tw_cmd_serializer_tb_top.sv
module tw_cmd_serializer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // checked instance
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = '0;
  logic [7:0]    req_addr = '0;
  logic [15:0]   req_data = '0;
  logic [DW-1:0] half_cnt = '0;
  logic busy, done, err, lcd_cs_n, lcd_sclk, lcd_sdo, lcd_sdo_oe, lcd_sdi;

  // monitor state
  logic cap [0:63];
  int   cap_n = 0;
  int   low_run = 0;
  int   high_run = 0;
  int   bad_len = 0;
  int   done_cnt = 0;
  int   exp_half = 1;
  int   cs_glitch = 0;
  logic prev_sclk = 1'b1;
  logic prev_cs = 1'b1;
  logic inj_en = 1'b0;
  int   inj_idx = 0;

  assign lcd_sdi = lcd_sdo ^ (inj_en && (cap_n == inj_idx));

  tw_cmd_serializer #(.DIV_W(DW), .CHECK_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .half_cnt(half_cnt), .busy(busy), .done(done), .err(err),
    .lcd_cs_n(lcd_cs_n), .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo),
    .lcd_sdo_oe(lcd_sdo_oe), .lcd_sdi(lcd_sdi)
  );

  // unchecked instance, read-back tied low
  logic nc_valid = 1'b0;
  logic nc_ready, nc_busy, nc_done, nc_err, nc_cs_n, nc_sclk, nc_sdo, nc_oe;
  logic nc_prev_sclk = 1'b1;
  logic nc_prev_cs = 1'b1;
  int   nc_rises = 0;
  int   nc_done_cnt = 0;

  tw_cmd_serializer #(.DIV_W(DW), .CHECK_EN(1'b0)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .req_valid(nc_valid), .req_ready(nc_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .half_cnt(half_cnt), .busy(nc_busy), .done(nc_done), .err(nc_err),
    .lcd_cs_n(nc_cs_n), .lcd_sclk(nc_sclk), .lcd_sdo(nc_sdo),
    .lcd_sdo_oe(nc_oe), .lcd_sdi(1'b0)
  );

  // link monitors, sampled on the falling system-clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !lcd_cs_n) begin
        cap_n = 0; low_run = 0; high_run = 0; bad_len = 0; done_cnt = 0;
      end
      if (!prev_cs && lcd_cs_n && !done) cs_glitch++;
      if (!lcd_cs_n && !lcd_sclk && prev_sclk && !prev_cs) begin
        if (high_run != exp_half) bad_len++;
        high_run = 0;
      end
      if (!lcd_cs_n && lcd_sclk && !prev_sclk) begin
        if (low_run != exp_half) bad_len++;
        low_run = 0;
        if (cap_n < 64) cap[cap_n] = lcd_sdo;
        cap_n++;
      end
      if (!lcd_cs_n && !lcd_sclk) low_run++;
      if (!lcd_cs_n && lcd_sclk) high_run++;
      if (done) done_cnt++;
      prev_sclk = lcd_sclk;
      prev_cs   = lcd_cs_n;

      if (nc_prev_cs && !nc_cs_n) begin nc_rises = 0; nc_done_cnt = 0; end
      if (!nc_cs_n && nc_sclk && !nc_prev_sclk) nc_rises++;
      if (nc_done) nc_done_cnt++;
      nc_prev_sclk = nc_sclk;
      nc_prev_cs   = nc_cs_n;
    end
  end

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent model of the word stream
  task automatic build_exp(input logic [1:0] kind, input logic [7:0] addr,
                           input logic [15:0] data, output logic [26:0] bits, output int n);
    bits = '0;
    bits[26:18] = {1'b0, addr};
    n = 9;
    if (kind == 2'd1) begin
      bits[17:9] = {1'b1, data[7:0]}; n = 18;
    end else if (kind == 2'd2) begin
      bits[17:9] = {1'b1, data[15:8]};
      bits[8:0]  = {1'b1, data[7:0]}; n = 27;
    end
  endtask

  task automatic start_req(input logic [1:0] kind, input logic [7:0] addr,
                           input logic [15:0] data, input int half, output logic err_after);
    @(negedge clk);
    req_kind = kind; req_addr = addr; req_data = data;
    half_cnt = DW'(half);
    exp_half = (half == 0) ? 1 : half;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    err_after = err;
  endtask

  task automatic wait_done(input string req, output logic got);
    got = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    chk(req, got, int'(got), 1);
  endtask

  // full frame with read-back of bits against the model
  task automatic t_frame(input string req, input logic [1:0] kind, input logic [7:0] addr,
                         input logic [15:0] data, input int half);
    logic [26:0] eb; int n; logic got; logic ea; int mism;
    build_exp(kind, addr, data, eb, n);
    start_req(kind, addr, data, half, ea);
    wait_done(req, got);
    chk({req, " idle at done (R7)"}, lcd_cs_n && lcd_sclk, int'({lcd_cs_n, lcd_sclk}), 3);
    chk({req, " no error"}, !err, int'(err), 0);
    chk({req, " bit count"}, cap_n == n, cap_n, n);
    mism = 0;
    for (int i = 0; i < n && i < 64; i++) if (cap[i] !== eb[26-i]) mism++;
    chk({req, " bit order/values (R1)"}, mism == 0, mism, 0);
    chk({req, " half-period lengths (R4)"}, bad_len == 0, bad_len, 0);
    @(negedge clk);
    chk({req, " done single pulse (R7)"}, done_cnt == 1 && !done, done_cnt, 1);
    chk({req, " back to idle (R5)"}, !busy && req_ready && lcd_cs_n && !lcd_sdo_oe, int'(busy), 0);
  endtask

  task automatic t_reset;
    chk("R5 reset cs_n", lcd_cs_n == 1'b1, int'(lcd_cs_n), 1);
    chk("R5 reset sclk", lcd_sclk == 1'b1, int'(lcd_sclk), 1);
    chk("R5 reset sdo/oe", !lcd_sdo && !lcd_sdo_oe, int'({lcd_sdo, lcd_sdo_oe}), 0);
    chk("R5 reset busy/done/err", !busy && !done && !err, int'({busy, done, err}), 0);
    chk("R5 reset ready", req_ready == 1'b1, int'(req_ready), 1);
  endtask

  task automatic t_busy_ignore;
    logic ea; logic got; int busy_seen;
    start_req(2'd0, 8'h11, 16'h0, 2, ea);
    repeat (4) @(negedge clk);
    chk("R9 ready low while busy", busy && !req_ready, int'(req_ready), 0);
    req_kind = 2'd2; req_addr = 8'hEE; req_data = 16'hABCD;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R9 frame ends", got);
    chk("R9 only first frame sent", cap_n == 9, cap_n, 9);
    busy_seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy || !lcd_cs_n) busy_seen++;
    end
    chk("R9 ignored request started nothing", busy_seen == 0, busy_seen, 0);
  endtask

  task automatic t_abort;
    logic ea; logic got; int mism; logic [26:0] eb; int n;
    build_exp(2'd2, 8'hB8, 16'h8002, eb, n);
    inj_idx = 12; inj_en = 1'b1;
    start_req(2'd2, 8'hB8, 16'h8002, 1, ea);
    wait_done("R6 abort reaches done", got);
    chk("R7 select and clock idle at abort done", lcd_cs_n && lcd_sclk, int'({lcd_cs_n, lcd_sclk}), 3);
    chk("R6 error raised", err == 1'b1, int'(err), 1);
    chk("R6 failing bit gets no rising edge", cap_n == 12, cap_n, 12);
    mism = 0;
    for (int i = 0; i < 12; i++) if (cap[i] !== eb[26-i]) mism++;
    chk("R6 bits before the fault", mism == 0, mism, 0);
    inj_en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 error holds while idle", err == 1'b1, int'(err), 1);
    chk("R3 select never rose early", cs_glitch == 0, cs_glitch, 0);
    start_req(2'd0, 8'h28, 16'h0, 1, ea);
    chk("R10 accepted request clears error", ea == 1'b0, int'(ea), 0);
    wait_done("R10 clean frame ends", got);
    chk("R10 error stays clear", !err, int'(err), 0);
    @(negedge clk);
  endtask

  task automatic t_nocheck;
    logic got;
    @(negedge clk);
    req_kind = 2'd2; req_addr = 8'hB8; req_data = 16'hFFF9; half_cnt = DW'(2);
    nc_valid = 1'b1;
    @(negedge clk);
    nc_valid = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (nc_done) begin got = 1'b1; break; end
    end
    chk("R8 frame ends", got, int'(got), 1);
    chk("R8 no error with read-back ignored", !nc_err, int'(nc_err), 0);
    chk("R8 all bits clocked", nc_rises == 27, nc_rises, 27);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame("R2 command only", 2'd0, 8'h29, 16'h1234, 2);
    t_frame("R2 command plus byte", 2'd1, 8'hBC, 16'h5580, 1);
    t_frame("R2 command plus 16-bit high first", 2'd2, 8'hB8, 16'hFFF9, 3);
    t_frame("R2 kind 3 as command only", 2'd3, 8'h00, 16'hFFFF, 1);
    t_frame("R4 half count zero as one", 2'd2, 8'hC3, 16'h2040, 0);
    chk("R3 select held across words", cs_glitch == 0, cs_glitch, 0);
    t_busy_ignore();
    t_abort();
    t_nocheck();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule